// File: doc/BRIEF.md
# Down-Counting System Event Timer

A single countdown timer for scheduling one event at a time. Software turns on the timer's clock gate through a control register and then writes a tick count into a value register. Each cycle in which the tick-enable input is high takes one from the count. When the count reaches zero the timer stops and latches a pending flag. The interrupt line is driven when that flag is set and interrupts are enabled.

The clock-gate bit controls more than counting. A value write is dropped while the gate is off. Interrupt settings can only be changed by a control write made while the gate is already on. Writing zero to the control register halts the timer. The interrupt is acknowledged through a self-clearing bit in the control register, not through a separate register. Any prescaler or clock-source selection sits outside this block.

Top module: `sys_event_timer`

## Requirements
- R1: After reset, the control register reads 0, the value register reads 0 and `irqOut` is low.
- R2: The control register is at offset 0x40. Its bit 0 is the gate, bit 1 is the interrupt enable and bit 4 is the acknowledge strobe, which always reads 0. The value register is at offset 0x44 and reads the remaining count. Every other offset reads 0.
- R3: A value write while the gate is on loads the count and starts the countdown in the same edge. The count then drops by exactly one at each edge where `tickEn` is high.
- R4: A value write while the gate is off is ignored, and the count keeps its old value.
- R5: A written value below 3 is loaded as 3. Every value from 3 up to 0xFFFFFFFF is loaded unchanged.
- R6: When the count steps from 1 to 0, counting stops and the pending flag is set. `irqOut` equals pending AND interrupt enable, and it rises right after that edge.
- R7: A control write with bit 0 set while the gate is off turns the gate on and leaves the interrupt enable cleared, whatever bit 1 holds. Bit 1 is taken only when the gate is already on.
- R8: A control write with bits 4 and 0 both set while the gate is on clears the pending flag and the interrupt enable.
- R9: A control write with bit 0 clear turns off the gate and the interrupt enable and stops counting. The count keeps its value.
- R10: Turning the gate back on does not resume a frozen countdown. The count stays put until a new value is written.
- R11: When a value write and a high `tickEn` fall in the same cycle, the written value is loaded and the tick is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational from `busAddr`) |
| tickEn | input | 1 | Count-down enable for this cycle |
| irqOut | output | 1 | Interrupt request |

## Verification
A wrong count shows up in the value register on the next read. It also shifts the edge where `irqOut` rises by the size of the error, and the per-cycle check against the bench model catches that in the same cycle. A gate or enable state that drifts from the model shows in the control register readback. It also shows as `irqOut` firing when it should not, or staying low when it should fire, at the next expiry. Random traffic mixes ignored writes, halts, re-enables and acknowledges, so these faults surface within a few dozen cycles.

// File: rtl/sevt_pkg.sv
package sevt_pkg;
  localparam int EN_BIT  = 0;
  localparam int IE_BIT  = 1;
  localparam int CLR_BIT = 4;

  typedef struct packed {
    logic load;  // accepted value write
    logic halt;  // control write with gate bit clear
  } dp_strobe_t;
endpackage

// File: rtl/sevt_datapath.sv
module sevt_datapath
  import sevt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MIN_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [DATA_W-1:0] loadVal,
  input  logic              tickEn,
  output logic [DATA_W-1:0] count,
  output logic              running,
  output logic              expire
);
  localparam logic [DATA_W-1:0] MinVal = DATA_W'(MIN_TICKS);
  localparam logic [DATA_W-1:0] One    = DATA_W'(1);

  logic [DATA_W-1:0] clampVal;
  logic              stepOk;

  assign clampVal = (loadVal < MinVal) ? MinVal : loadVal;
  assign stepOk   = running && tickEn && !strb.load && !strb.halt;
  assign expire   = stepOk && (count == One);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      if (strb.load)   count <= clampVal;
      else if (stepOk) count <= count - One;

      if (strb.load)      running <= 1'b1;
      else if (strb.halt) running <= 1'b0;
      else if (expire)    running <= 1'b0;
    end
  end

  AST_LOAD_MIN: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (count >= MinVal) && running); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && !strb.load && !strb.halt) |=> count == $past(count) - One); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.load) |=> $stable(count)); // R10
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (!running && count == '0)); // R6
endmodule

// File: rtl/sevt_ctrl.sv
module sevt_ctrl
  import sevt_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h40,
  parameter logic [ADDR_W-1:0] VALUE_OFS = 8'h44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  output dp_strobe_t        strb,
  output logic              irqOut
);
  logic gateOn;
  logic irqEn;
  logic pending;
  logic ctrlWr;
  logic valueWr;
  logic ackHit;

  assign ctrlWr  = busSel && busWrite && (busAddr == CTRL_OFS);
  assign valueWr = busSel && busWrite && (busAddr == VALUE_OFS);
  assign ackHit  = ctrlWr && gateOn && busWdata[EN_BIT] && busWdata[CLR_BIT];

  always_comb begin
    strb      = '0;
    strb.load = valueWr && gateOn;
    strb.halt = ctrlWr && !busWdata[EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateOn  <= 1'b0;
      irqEn   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (strb.halt) begin
        gateOn <= 1'b0;
        irqEn  <= 1'b0;
      end else if (ctrlWr) begin
        if (gateOn) irqEn <= busWdata[CLR_BIT] ? 1'b0 : busWdata[IE_BIT];
        else        gateOn <= 1'b1;
      end

      if (ackHit)      pending <= 1'b0;
      else if (expire) pending <= 1'b1;
    end
  end

  assign irqOut = pending && irqEn;

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_OFS) begin
      busRdata[EN_BIT] = gateOn;
      busRdata[IE_BIT] = irqEn;
    end else if (busAddr == VALUE_OFS) begin
      busRdata = count;
    end
  end

  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.halt |=> (!gateOn && !irqEn)); // R9
  AST_IE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !gateOn) |=> !irqEn); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ackHit |=> (!pending && !irqEn && !irqOut)); // R8
  AST_PEND_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ackHit) |=> pending); // R6
endmodule

// File: rtl/sys_event_timer.sv
module sys_event_timer
  import sevt_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h40,
  parameter logic [ADDR_W-1:0] VALUE_OFS = 8'h44,
  parameter int              MIN_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  output logic              irqOut
);
  dp_strobe_t        strb;
  logic [DATA_W-1:0] count;
  logic              running;
  logic              expire;

  sevt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .VALUE_OFS(VALUE_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .count(count), .expire(expire), .strb(strb), .irqOut(irqOut)
  );

  sevt_datapath #(
    .DATA_W(DATA_W), .MIN_TICKS(MIN_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(busWdata),
    .tickEn(tickEn), .count(count), .running(running), .expire(expire)
  );
endmodule

// File: tb/sys_event_timer_bench.sv
module sys_event_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        tickEn = 1'b0;
  logic        irqOut;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state
  bit          mEn, mIe, mPend, mRun;
  logic [31:0] mCount;

  localparam logic [7:0] ACTRL = 8'h40;
  localparam logic [7:0] AVAL  = 8'h44;

  always #10 clk = ~clk; // 50 MHz

  sys_event_timer u_sys_event_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (a == ACTRL) return {30'b0, mIe, mEn};
    if (a == AVAL)  return mCount;
    return 32'h0;
  endfunction

  function automatic logic [31:0] clampLoad(input logic [31:0] d);
    return (d < 32'd3) ? 32'd3 : d;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle; called at a negedge, returns at the next negedge
  task automatic step(input string tag, input bit s, input bit w,
                      input logic [7:0] a, input logic [31:0] d, input bit t);
    bit ctrlW, valW, halt, expired, ack;
    busSel = s; busWrite = w; busAddr = a; busWdata = d; tickEn = t;
    #1;
    if (s && !w) check(tag, busRdata, expRead(a));
    ctrlW = s && w && a == ACTRL;
    valW  = s && w && a == AVAL;
    halt  = ctrlW && !d[0];
    ack   = ctrlW && mEn && d[0] && d[4];
    expired = 1'b0;
    @(posedge clk);
    if (valW && mEn) begin
      mCount = clampLoad(d); mRun = 1'b1;                // R3 R5 R11
    end else if (mRun && t && !halt) begin
      if (mCount == 32'd1) begin expired = 1'b1; mRun = 1'b0; end
      mCount = mCount - 32'd1;
    end
    if (halt) begin mEn = 0; mIe = 0; mRun = 0; end      // R9
    else if (ctrlW) begin
      if (mEn) mIe = d[4] ? 1'b0 : d[1];                  // R8
      else     mEn = 1'b1;                                // R7
    end
    if (ack) mPend = 1'b0;
    else if (expired) mPend = 1'b1;
    @(negedge clk);
    check("R6 irq", {31'b0, irqOut}, {31'b0, mPend & mIe});
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input bit t);
    step(tag, 1'b1, 1'b0, a, 32'h0, t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit t);
    step("wr", 1'b1, 1'b1, a, d, t);
  endtask

  task automatic idle(input int n, input bit t);
    for (int i = 0; i < n; i++) step("idle", 1'b0, 1'b0, 8'h0, 32'h0, t);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cw [6];
    cw[0] = 32'h0; cw[1] = 32'h1; cw[2] = 32'h2;
    cw[3] = 32'h3; cw[4] = 32'h11; cw[5] = 32'h13;
    void'($urandom(32'd20240611));
    mEn = 0; mIe = 0; mPend = 0; mRun = 0; mCount = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd("R1 ctrl", ACTRL, 1'b0);
    rd("R1 value", AVAL, 1'b0);
    // R2 unmapped offset reads zero
    rd("R2 other", 8'h48, 1'b0);
    // R4 value write ignored when gate off
    wr(AVAL, 32'd10, 1'b1);
    rd("R4 value", AVAL, 1'b0);
    // R7 gate on with bit1 set leaves interrupt enable clear
    wr(ACTRL, 32'h3, 1'b0);
    rd("R7 ctrl", ACTRL, 1'b0);
    wr(ACTRL, 32'h3, 1'b0);
    rd("R2 ctrl", ACTRL, 1'b0);
    // R5 clamp to three, R6 expiry and interrupt
    wr(AVAL, 32'd1, 1'b0);
    rd("R5 value", AVAL, 1'b0);
    idle(3, 1'b1);
    rd("R6 value", AVAL, 1'b1);
    // R8 acknowledge clears pending and enable
    wr(ACTRL, 32'h13, 1'b0);
    rd("R8 ctrl", ACTRL, 1'b0);
    wr(ACTRL, 32'h3, 1'b0);
    rd("R8 still clear", ACTRL, 1'b0);
    // R5 maximum load, R3 stepping
    wr(AVAL, 32'hFFFF_FFFF, 1'b1);
    idle(2, 1'b1);
    rd("R3 value", AVAL, 1'b0);
    // R9 halt freezes, R10 no resume on re-enable, R11 write beats tick
    wr(AVAL, 32'd50, 1'b0);
    idle(5, 1'b1);
    wr(ACTRL, 32'h0, 1'b1);
    rd("R9 ctrl", ACTRL, 1'b1);
    idle(5, 1'b1);
    rd("R9 value", AVAL, 1'b1);
    wr(ACTRL, 32'h1, 1'b1);
    idle(5, 1'b1);
    rd("R10 value", AVAL, 1'b1);
    wr(AVAL, 32'd7, 1'b1);
    rd("R11 value", AVAL, 1'b0);
    // constrained random traffic
    for (int k = 0; k < 4000; k++) begin
      int op;
      bit t;
      op = int'($urandom % 10);
      t  = ($urandom % 4) != 0;
      case (op)
        0, 1, 2, 3: rd("R3 rand value", AVAL, t);
        4:          rd("R2 rand ctrl", ACTRL, t);
        5, 6:       wr(ACTRL, cw[$urandom % 6], t);
        7, 8:       wr(AVAL, $urandom % 12, t);
        default:    rd("R2 rand other", 8'h4C, t);
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule